// File: doc/BRIEF.md
# Asymmetric Fault Qualification Filter

This block cleans up one active-high fault indication (overcurrent, overvoltage, overtemperature and similar) before it reaches the protection logic of a motor drive. Upstream analog filtering already exists. This digital stage adds a second layer so that noise cannot raise a false alarm. It first passes the raw input through a two-stage synchronizer. All timing is then measured in ticks of a timebase strobe that comes from an external prescaler.

Three separate durations shape the response:
- A fault too short to span the glitch threshold leaves no trace at all.
- A fault must stay present without a break for more than the qualification count before protection is raised.
- Once raised, protection is held for a fixed number of ticks after the fault goes away.
- If the fault returns during that hold, the hold restarts and protection never drops.

A status output shows the qualifying phase: the fault is present and has been seen, but protection is not yet raised.

Top module: `fault_qual_filter`

## Requirements
- R1: When `rst` is high at a rising clock edge, `protect` and `qualifying` are both low after that edge, and all counting restarts from zero.
- R2: A fault pulse that spans fewer than GLITCH_TICKS (default 1) timebase ticks has no effect: neither `qualifying` nor `protect` ever goes high.
- R3: `qualifying` is high only while the synchronized fault is present, at least GLITCH_TICKS ticks have been counted, and `protect` is still low. It goes low within one cycle after the synchronized fault drops.
- R4: `protect` rises on the (ASSERT_TICKS+1)-th tick (default 21st) of an unbroken fault. A fault that spans ASSERT_TICKS ticks or fewer never raises it.
- R5: The qualification count returns to zero whenever the synchronized fault drops before the threshold. Two 15-tick faults separated by a gap therefore do not raise `protect`.
- R6: After the fault clears, `protect` stays high through HOLD_TICKS-1 ticks (default 29) and falls on the HOLD_TICKS-th tick (default 30).
- R7: A fault that returns while protection is being held restarts the hold count and keeps `protect` high without qualifying again. Release then comes HOLD_TICKS ticks after the final clearing.
- R8: `protect` and `qualifying` are never high together.
- R9: The raw fault passes two synchronizer flops before any counting. A fault raised just after a tick is not counted on the following tick unless it was present two cycles before that tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle timebase strobe from the prescaler |
| fault_in | input | 1 | Raw active-high fault input, asynchronous |
| protect | output | 1 | Qualified protection request |
| qualifying | output | 1 | Fault present and counted, protection not yet raised |

## Verification
Fault pulses are swept in whole numbers of ticks from a single-cycle glitch up to well past the qualification threshold. This places the boundary between 20 and 21 ticks exactly, and it separates the glitch case from a one-tick fault through the status output. Release is timed tick by tick after the fault clears, so the 29- and 30-tick points are told apart. A fault that comes back in the middle of the hold shows whether the hold restarts or runs on. Two sub-threshold faults in a row show whether the qualification count leaks across a gap, and a reset in the middle of protection shows that the state clears at once.

// File: rtl/fq_pkg.sv
package fq_pkg;

    typedef enum logic [1:0] {
        FQ_IDLE = 2'd0,
        FQ_QUAL = 2'd1,
        FQ_PROT = 2'd2
    } fq_state_t;

    typedef struct packed {
        logic qual_clr;
        logic qual_inc;
        logic hold_clr;
        logic hold_inc;
    } fq_ctrl_t;

    function automatic int fq_max(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic int fq_width(input int v);
        return (v < 2) ? 1 : $clog2(v + 1);
    endfunction

endpackage

// File: rtl/fq_sync.sv
module fq_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/fq_tick_counter.sv
module fq_tick_counter #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] cnt
);
    always_ff @(posedge clk) begin
        if (rst || clr)            cnt <= '0;
        else if (inc && cnt != '1) cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/fq_fsm.sv
module fq_fsm
    import fq_pkg::*;
#(
    parameter int GLITCH_TICKS = 1,
    parameter int ASSERT_TICKS = 20,
    parameter int HOLD_TICKS   = 30,
    parameter int CNT_W        = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             fault_s,
    input  logic [CNT_W-1:0] qual_cnt,
    input  logic [CNT_W-1:0] hold_cnt,
    output fq_ctrl_t         ctrl,
    output logic             protect,
    output logic             qualifying
);
    localparam logic [CNT_W-1:0] QUAL_LAST  = CNT_W'(ASSERT_TICKS);
    localparam logic [CNT_W-1:0] HOLD_LAST  = CNT_W'(HOLD_TICKS - 1);
    localparam logic [CNT_W-1:0] GLITCH_MIN = CNT_W'(GLITCH_TICKS);

    fq_state_t state, state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            FQ_IDLE: if (fault_s) state_nx = FQ_QUAL;
            FQ_QUAL: begin
                if (!fault_s)                      state_nx = FQ_IDLE;
                else if (tick && qual_cnt == QUAL_LAST) state_nx = FQ_PROT;
            end
            FQ_PROT: if (!fault_s && tick && hold_cnt == HOLD_LAST) state_nx = FQ_IDLE;
            default: state_nx = FQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= FQ_IDLE;
        else     state <= state_nx;
    end

    always_comb begin
        ctrl.qual_clr = (state != FQ_QUAL) || !fault_s;
        ctrl.qual_inc = (state == FQ_QUAL) && fault_s && tick;
        ctrl.hold_clr = (state != FQ_PROT) || fault_s;
        ctrl.hold_inc = (state == FQ_PROT) && !fault_s && tick;
    end

    assign protect    = (state == FQ_PROT);
    assign qualifying = (state == FQ_QUAL) && (qual_cnt >= GLITCH_MIN);
endmodule

// File: rtl/fault_qual_filter.sv
module fault_qual_filter
    import fq_pkg::*;
#(
    parameter int GLITCH_TICKS = 1,
    parameter int ASSERT_TICKS = 20,
    parameter int HOLD_TICKS   = 30,
    parameter int SYNC_STAGES  = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic fault_in,
    output logic protect,
    output logic qualifying
);
    localparam int CNT_W = fq_width(fq_max(ASSERT_TICKS, HOLD_TICKS));

    logic             fault_s;
    logic [CNT_W-1:0] qual_cnt;
    logic [CNT_W-1:0] hold_cnt;
    fq_ctrl_t         ctrl;

    fq_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .d(fault_in), .q(fault_s)
    );

    fq_tick_counter #(.W(CNT_W)) u_qual_cnt (
        .clk(clk), .rst(rst), .clr(ctrl.qual_clr), .inc(ctrl.qual_inc), .cnt(qual_cnt)
    );

    fq_tick_counter #(.W(CNT_W)) u_hold_cnt (
        .clk(clk), .rst(rst), .clr(ctrl.hold_clr), .inc(ctrl.hold_inc), .cnt(hold_cnt)
    );

    fq_fsm #(
        .GLITCH_TICKS(GLITCH_TICKS), .ASSERT_TICKS(ASSERT_TICKS),
        .HOLD_TICKS(HOLD_TICKS), .CNT_W(CNT_W)
    ) u_fsm (
        .clk(clk), .rst(rst), .tick(tick), .fault_s(fault_s),
        .qual_cnt(qual_cnt), .hold_cnt(hold_cnt), .ctrl(ctrl),
        .protect(protect), .qualifying(qualifying)
    );
endmodule

// File: rtl/fq_checker.sv
module fq_checker (
    input logic clk,
    input logic rst,
    input logic tick,
    input logic fault_s,
    input logic protect,
    input logic qualifying
);
    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (!protect && !qualifying));

    a_r3_qual_needs_fault: assert property (@(posedge clk) disable iff (rst)
        !fault_s |=> !qualifying);

    a_r4_rise_on_tick: assert property (@(posedge clk) disable iff (rst)
        ($rose(protect) && !$past(rst)) |-> ($past(tick) && $past(fault_s)));

    a_r6_fall_on_tick: assert property (@(posedge clk) disable iff (rst)
        ($fell(protect) && !$past(rst)) |-> ($past(tick) && !$past(fault_s)));

    a_r7_hold_on_fault: assert property (@(posedge clk) disable iff (rst)
        (protect && fault_s) |=> protect);

    a_r8_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(protect && qualifying));
endmodule

bind fault_qual_filter fq_checker u_chk (
    .clk(clk), .rst(rst), .tick(tick), .fault_s(fault_s),
    .protect(protect), .qualifying(qualifying)
);

// File: tb/tb_fault_qual_filter.sv
module tb_fault_qual_filter;
    localparam int ASSERT_T = 20;
    localparam int HOLD_T   = 30;
    localparam int TPER     = 4;

    logic clk = 0, rst = 1, tick = 0, fault_in = 0;
    logic protect, qualifying;
    int   checks = 0, errors = 0;
    int   phase = 0;
    logic saw_q = 0, saw_p = 0, saw_both = 0;
    bit   done = 0;

    fault_qual_filter dut (
        .clk(clk), .rst(rst), .tick(tick), .fault_in(fault_in),
        .protect(protect), .qualifying(qualifying)
    );

    always #4 clk = ~clk;

    always @(negedge clk) begin
        phase <= (phase == TPER - 1) ? 0 : phase + 1;
        tick  <= (phase == TPER - 1);
    end

    always @(posedge clk) begin
        if (qualifying) saw_q <= 1;
        if (protect) saw_p <= 1;
        if (protect && qualifying) saw_both <= 1;
    end

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0b expected %0b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic wait_ticks(input int n);
        for (int i = 0; i < n; i++) begin
            do @(negedge clk); while (tick !== 1'b1);
        end
    endtask

    task automatic clear_flags();
        @(negedge clk);
        saw_q = 0; saw_p = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk("R1 reset protect", protect, 0);
        chk("R1 reset qualifying", qualifying, 0);

        // R2/R4 sweep over pulse length in ticks
        for (int k = 0; k <= 24; k++) begin
            wait_ticks(1);
            saw_q = 0; saw_p = 0;
            fault_in = 1;
            if (k == 0) @(negedge clk);
            else wait_ticks(k);
            fault_in = 0;
            repeat (6) @(negedge clk);
            chk($sformatf("R2/R3 qualifying seen k=%0d", k), saw_q, k >= 1);
            chk($sformatf("R4 protect seen k=%0d", k), saw_p, k > ASSERT_T);
            wait_ticks((k > ASSERT_T) ? HOLD_T + 3 : 2);
            chk($sformatf("R6 released k=%0d", k), protect, 0);
        end

        // R3/R4/R9: exact tick boundaries of qualification
        wait_ticks(1);
        fault_in = 1;
        repeat (2) @(negedge clk);
        chk("R9 not counted before first tick", qualifying, 0);
        wait_ticks(1);
        chk("R3 qualifying after 1 tick", qualifying, 1);
        wait_ticks(ASSERT_T - 1);
        chk("R4 no protect after 20 ticks", protect, 0);
        chk("R3 still qualifying after 20 ticks", qualifying, 1);
        wait_ticks(1);
        chk("R4 protect after 21 ticks", protect, 1);
        chk("R8 qualifying low under protect", qualifying, 0);

        // R7: fault returns mid-hold
        fault_in = 0;
        wait_ticks(10);
        chk("R6 held mid-hold", protect, 1);
        fault_in = 1;
        wait_ticks(5);
        chk("R7 protect kept while fault back", protect, 1);
        fault_in = 0;
        wait_ticks(HOLD_T - 1);
        chk("R7 hold restarted: high at 29", protect, 1);
        wait_ticks(1);
        chk("R6/R7 released at 30", protect, 0);

        // R5: two sub-threshold pulses with a gap
        wait_ticks(2);
        clear_flags();
        fault_in = 1; wait_ticks(15); fault_in = 0;
        wait_ticks(2);
        fault_in = 1; wait_ticks(15); fault_in = 0;
        wait_ticks(2);
        chk("R5 count restarted, no protect", saw_p, 0);
        chk("R5 qualifying seen", saw_q, 1);

        // R1: reset in the middle of protection
        fault_in = 1;
        wait_ticks(ASSERT_T + 2);
        chk("R4 protect before reset", protect, 1);
        rst = 1;
        @(negedge clk);
        chk("R1 reset clears protect", protect, 0);
        chk("R1 reset clears qualifying", qualifying, 0);
        fault_in = 0;
        rst = 0;
        wait_ticks(3);
        chk("R1 stays idle after reset", protect, 0);

        chk("R8 never both high", saw_both, 0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule